// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that counts clock cycles through three stages: a fixed integer pre-divider, a power-of-two prescaler picked by a 3-bit select field, and a wide timeout counter. Software controls it through one 8-bit control register. The register holds an enable, a clear command that clears itself, a run-during-idle enable and the prescaler select. Firmware has to write the clear command regularly. If it stops doing so while the watchdog is enabled, the timeout counter overflows and the block raises a reset request for exactly one clock. The chip's reset generator turns that request into a system reset.

The idle status input tells the block that the processor is idle. Unless run-during-idle is set, the count freezes for every cycle in which idle is high. After a timeout the counter wraps to zero and keeps running. If it is left alone, a second request follows one full timeout period later.

Top module: `wdt_guard`

## Requirements
- R1: A synchronous reset clears the control register and all three counting stages. The block then reads back 0x00, raises no request and has no progress carried over from before the reset.
- R2: Control register bits: bit 7 is enable, bit 6 is clear, bit 5 is run-during-idle and bits 2:0 are the prescaler select n. Bits 4:3 are not stored and always read as 0.
- R3: With select n, the prescaler divides by 2^(n+1), so 000 gives 2 and 111 gives 256. After a write that sets both enable and clear, the timeout is FIX_DIV × 2^(n+1) × 2^CNT_W clock cycles. The request is high in the cycle that follows clock edge number timeout+1, counting the write edge as edge 0.
- R4: A write with bit 6 set clears the pre-divider, the prescaler and the timeout counter on the next clock edge. Bit 6 reads back 1 for only the one cycle between the write edge and that edge, and reads 0 after it.
- R5: While run-during-idle is 0, every cycle with the idle input high delays the timeout by one cycle.
- R6: While run-during-idle is 1, the idle input has no effect on the timeout.
- R7: While enable is 0, nothing counts and the request output stays low.
- R8: The request is one cycle wide, and the counter wraps to zero at overflow. An enabled watchdog that is never cleared raises its next request exactly one timeout later.
- R9: A clear written partway through a period restarts the timeout from the clearing write, and the request that was pending never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Processor idle status |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register readback |
| wdt_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with FIX_DIV = 3 and CNT_W = 6. The timeout then spans 384 cycles at select 000 and 49152 at select 111, so the shortest and longest prescaler settings both finish inside the run. These shorter periods also let the bench reach a wraparound pair of requests, a clear partway through a period, and exact idle stall counts at cycle precision. The structure is the same as with the default 12 and 14 bit settings; only the widths and divide value differ.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PSEL_W = 3;
    localparam int PRE_W  = 1 << PSEL_W;

    typedef struct packed {
        logic              en;
        logic              run_idle;
        logic [PSEL_W-1:0] psel;
    } wdt_cfg_t;

    localparam int BIT_EN   = 7;
    localparam int BIT_CLR  = 6;
    localparam int BIT_IDLE = 5;

    function automatic wdt_cfg_t cfg_decode(input logic [7:0] d);
        wdt_cfg_t c;
        c.en       = d[BIT_EN];
        c.run_idle = d[BIT_IDLE];
        c.psel     = d[PSEL_W-1:0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_encode(input wdt_cfg_t c, input logic clr);
        logic [7:0] d;
        d                = '0;
        d[BIT_EN]        = c.en;
        d[BIT_CLR]       = clr;
        d[BIT_IDLE]      = c.run_idle;
        d[PSEL_W-1:0]    = c.psel;
        return d;
    endfunction

    // Low n+1 bits set: the prescaler wraps once every 2^(n+1) input ticks.
    function automatic logic [PRE_W-1:0] pre_mask(input logic [PSEL_W-1:0] n);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            m[i] = (i <= int'(n));
        end
        return m;
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output wdt_cfg_t   cfg_o,
    output logic       clr_o,
    output logic [7:0] rd_data_o
);

    wdt_cfg_t cfg_q;
    logic     clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            clr_q <= 1'b0;
        end else if (wr_en_i) begin
            cfg_q <= cfg_decode(wr_data_i);
            clr_q <= wr_data_i[BIT_CLR];
        end else begin
            clr_q <= 1'b0;
        end
    end

    assign cfg_o     = cfg_q;
    assign clr_o     = clr_q;
    assign rd_data_o = cfg_encode(cfg_q, clr_q);

    // R4
    clr_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_q && !wr_en_i) |=> !clr_q);

    // R1
    rst_cfg_chk: assert property (@(posedge clk)
        rst |=> (rd_data_o == 8'h00));

    // R2
    unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[4:3] == 2'b00);

endmodule

// File: rtl/wdt_prediv.sv
module wdt_prediv
    import wdt_pkg::*;
#(
    parameter int FIX_DIV = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic              tick_o
);

    localparam int FDIV_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
    localparam logic [FDIV_W-1:0] FDIV_LAST = FDIV_W'(FIX_DIV - 1);

    logic [FDIV_W-1:0] fdiv_q;
    logic [PRE_W-1:0]  pre_q;
    logic              fix_tick;
    logic [PRE_W-1:0]  mask;

    assign fix_tick = run_i && !clr_i && (fdiv_q == FDIV_LAST);
    assign mask     = pre_mask(psel_i);
    assign tick_o   = fix_tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            fdiv_q <= '0;
        end else if (run_i) begin
            fdiv_q <= (fdiv_q == FDIV_LAST) ? '0 : fdiv_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (fix_tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clr_i) |=> ($stable(fdiv_q) && $stable(pre_q)));

    // R4
    clr_prediv_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (fdiv_q == '0 && pre_q == '0));

endmodule

// File: rtl/wdt_core_cnt.sv
module wdt_core_cnt #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic tick_i,
    output logic req_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic             ovf;

    assign ovf = tick_i && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            if (tick_i) cnt_q <= cnt_q + 1'b1;
            req_q <= ovf;
        end
    end

    assign req_o = req_q;

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (cnt_q == '0));

    // R4
    clr_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0 && !req_q));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int FIX_DIV = 12,
    parameter int CNT_W   = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       wdt_req_o
);

    wdt_cfg_t cfg;
    logic     clr;
    logic     run;
    logic     tick;

    wdt_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    assign run = cfg.en && (!idle_i || cfg.run_idle);

    wdt_prediv #(.FIX_DIV(FIX_DIV)) u_prediv (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .run_i  (run),
        .psel_i (cfg.psel),
        .tick_o (tick)
    );

    wdt_core_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .tick_i (tick),
        .req_o  (wdt_req_o)
    );

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !wdt_req_o);

    // R1
    rst_req_chk: assert property (@(posedge clk)
        rst |=> !wdt_req_o);

endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;

    localparam int FIX_DIV = 3;
    localparam int CNT_W   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       wdt_req_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    wdt_guard #(.FIX_DIV(FIX_DIV), .CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .idle_i    (idle_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .wdt_req_o (wdt_req_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(input int n);
        return FIX_DIV * (2 << n) * (1 << CNT_W);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every request must match the next scheduled expectation.
    always @(negedge clk) begin
        if (!rst && wdt_req_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R9 unexpected request", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R3/R8 request cycle", cyc, e);
            end
        end
    end

    // Driver: write control, verify clear readback, schedule expected request.
    task automatic write_cfg(input logic [7:0] v);
        int k;
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(posedge clk);
        #1 k = cyc;
        if (v[7] && v[6]) exp_q.push_back(k + period(int'(v[2:0])) + 1);
        @(negedge clk);
        wr_en_i = 1'b0;
        check(rd_data_o == (v & 8'hE7), "R2/R4 readback with clear", rd_data_o, v & 8'hE7);
        @(negedge clk);
        check(rd_data_o == (v & 8'hA7), "R4 clear self-clears", rd_data_o, v & 8'hA7);
    endtask

    task automatic drain(input int limit);
        int n = 0;
        while (exp_q.size() != 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "R3 expected request seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_data_o == 8'h00, "R1 reset readback", rd_data_o, 0);
        check(wdt_req_o == 1'b0, "R1 reset request", wdt_req_o, 0);

        // R2 unused bits read zero, disabled
        write_cfg(8'h18);

        // R3 R8 select 000 with wraparound
        write_cfg(8'hC0);
        exp_q.push_back(exp_q[0] + period(0));
        drain(1200);
        write_cfg(8'h00);

        // R6 idle ignored when run-during-idle is set
        write_cfg(8'hE2);
        idle_i = 1'b1;
        repeat (100) @(negedge clk);
        idle_i = 1'b0;
        drain(2000);
        write_cfg(8'h00);

        // R5 idle stalls count when run-during-idle is clear
        write_cfg(8'hC2);
        idle_i = 1'b1;
        repeat (100) @(negedge clk);
        idle_i = 1'b0;
        exp_q[0] = exp_q[0] + 100;
        drain(2000);
        write_cfg(8'h00);

        // R9 clear partway restarts the period
        write_cfg(8'hC2);
        repeat (1000) @(negedge clk);
        void'(exp_q.pop_back());
        write_cfg(8'hC2);
        drain(2000);
        write_cfg(8'h00);

        // R7 disabled: no request over several periods
        write_cfg(8'h40);
        repeat (1200) @(negedge clk);
        check(wdt_req_o == 1'b0, "R7 disabled no request", wdt_req_o, 0);
        check(rd_data_o == 8'h00, "R7 disabled readback", rd_data_o, 0);

        // R3 select 111
        write_cfg(8'hC7);
        drain(50000);
        write_cfg(8'h00);

        // R1 reset partway through a period
        write_cfg(8'hC0);
        repeat (100) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data_o == 8'h00, "R1 reset mid-period readback", rd_data_o, 0);
        repeat (500) @(negedge clk);
        check(wdt_req_o == 1'b0, "R1 no request after reset", wdt_req_o, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule